// File: doc/BRIEF.md
# Byte-Order Selectable Load/Store Unit

This unit sits between a 32-bit processor datapath and a byte-addressed data RAM that it holds internally. Each request carries an address, a size code, write data and a read/write flag. The unit moves one, two or four bytes per request. It routes the bytes to memory lanes according to a byte order that is captured while reset is held and stays fixed after that.

Addresses are checked before memory is touched. A halfword at an odd address, a word that is not on a four-byte boundary, an address beyond the configured memory, or the reserved size code each raise a bus-error fault. A faulting write leaves memory as it was. A faulting read returns zero. The response (valid, read data, fault) is registered and appears one clock after the request. The memory size is 2^ADDR_EXP bytes.

Top module: `endian_lsu`

## Requirements
- R1: With little-endian order captured (cfgBigEndian=0 during reset), a word store at address A writes data bits 7:0 to A, 15:8 to A+1, 23:16 to A+2 and 31:24 to A+3.
- R2: With little-endian order, a word load from A returns {mem[A+3], mem[A+2], mem[A+1], mem[A]}.
- R3: With little-endian order, a halfword access uses A as the low byte and A+1 as the high byte. With big-endian order (cfgBigEndian=1 during reset), the lane order of halfword and word accesses is reversed, so the byte at A becomes the most significant.
- R4: A halfword access (reqSize=1) with reqAddr[0]=1, or a word access (reqSize=2) with reqAddr[1:0]!=0, produces rspFault=1, and its rspRData is 0.
- R5: A faulting write changes no byte of memory.
- R6: The byte order is sampled from cfgBigEndian only while rstN is low. A change of cfgBigEndian while out of reset has no effect.
- R7: A byte access (reqSize=0) never faults for alignment. It reads or writes exactly the one byte at its address, in either byte order, and read data sits in bits 7:0.
- R8: An address with any bit at or above ADDR_EXP set, or the reserved size code 3, produces rspFault=1 and no memory change.
- R9: rspValid and rspFault are asserted for exactly the one cycle after an accepted request and are 0 after reset and when there is no request. A write response returns rspRData=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the byte order is captured while this is low |
| cfgBigEndian | input | 1 | Byte-order setting: 1 big-endian, 0 little-endian |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqAddr | input | 32 | Byte address |
| reqWData | input | 32 | Store data, right-aligned |
| rspValid | output | 1 | Response for last cycle's request |
| rspRData | output | 32 | Load data, right-aligned; zero on writes and faults |
| rspFault | output | 1 | Bus-error pulse |

## Verification
The bench stores a word and reads it back as single bytes, as halfwords and as a word in both byte orders. A design with a swapped or off-by-one lane map returns bytes in the wrong positions. The bench aims misaligned and out-of-range stores at bytes that were already written. A unit that writes before it checks, or that lets the address wrap at the top of memory, corrupts those bytes, and the bench reads them back to catch it. The bench also toggles the byte-order input outside reset and watches for reads that change, and it checks the cycle after a fault for a fault flag that stays high.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // Strobes from control to datapath for the current request
  typedef struct packed {
    logic       issue;      // a request is present
    logic       wrEn;       // commit store lanes
    logic       fault;      // bus error for this request
    logic       swapLanes;  // big-endian lane order
    logic [3:0] laneEn;     // memory lanes touched (base+k)
    logic [1:0] lastLane;   // bytes in access minus one
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgBigEndian,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [1:0] addrLow,
  input  logic       addrHigh,
  output lsuStrobe_t strobe
);
  logic bigMode;
  logic misaligned;
  logic sizeBad;
  logic [3:0] lanes;
  logic [1:0] last;

  // Byte order captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) bigMode <= cfgBigEndian;
  end

  always_comb begin
    misaligned = 1'b0;
    sizeBad    = 1'b0;
    lanes      = 4'b0000;
    last       = 2'd0;
    case (accSize_e'(reqSize))
      SZ_BYTE: begin lanes = 4'b0001; last = 2'd0; end
      SZ_HALF: begin lanes = 4'b0011; last = 2'd1; misaligned = addrLow[0]; end
      SZ_WORD: begin lanes = 4'b1111; last = 2'd3; misaligned = |addrLow; end
      default: sizeBad = 1'b1;
    endcase
  end

  always_comb begin
    strobe.issue     = reqValid;
    strobe.fault     = reqValid && (misaligned || sizeBad || addrHigh);
    strobe.wrEn      = reqValid && reqWrite && !strobe.fault;
    strobe.laneEn    = (reqValid && !strobe.fault) ? lanes : 4'b0000;
    strobe.lastLane  = last;
    strobe.swapLanes = bigMode;
  end

  // R6: byte order never moves once out of reset
  p_endian_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bigMode));
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int ADDR_EXP = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsuStrobe_t          strobe,
  input  logic [ADDR_EXP-1:0] baseAddr,
  input  logic [31:0]         reqWData,
  output logic                rspValid,
  output logic [31:0]         rspRData,
  output logic                rspFault
);
  localparam int MEM_BYTES = 1 << ADDR_EXP;
  localparam int LANES     = 4;

  logic [7:0] mem [MEM_BYTES];
  logic [ADDR_EXP-1:0] laneAddr [LANES];
  logic [1:0]          laneSlot [LANES];
  logic [7:0]          wrByte   [LANES];
  logic [31:0]         rdWord;

  // Map each memory lane to its position in the data word
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneAddr[k] = baseAddr + ADDR_EXP'(k);
    assign laneSlot[k] = strobe.swapLanes ? (strobe.lastLane - 2'(k)) : 2'(k);
    assign wrByte[k]   = 8'(reqWData >> {laneSlot[k], 3'b000});

    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.laneEn[k]) mem[laneAddr[k]] <= wrByte[k];
    end
  end

  always_comb begin
    rdWord = 32'd0;
    if (!strobe.wrEn) begin
      for (int k = 0; k < LANES; k++) begin
        if (strobe.laneEn[k])
          rdWord = rdWord | ({24'd0, mem[laneAddr[k]]} << {laneSlot[k], 3'b000});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspRData <= 32'd0;
    end else begin
      rspValid <= strobe.issue;
      rspFault <= strobe.fault;
      rspRData <= rdWord;
    end
  end

  // R5: a faulting request never reaches the store path
  p_fault_no_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |-> (strobe.laneEn == 4'b0000));

  // R4: faulting responses carry zero data
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspRData == 32'd0));
endmodule

// File: rtl/endian_lsu.sv
module endian_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_EXP = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgBigEndian,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWData,
  output logic        rspValid,
  output logic [31:0] rspRData,
  output logic        rspFault
);
  lsuStrobe_t strobe;
  logic addrHigh;

  assign addrHigh = |reqAddr[31:ADDR_EXP];

  lsu_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgBigEndian (cfgBigEndian),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .addrLow      (reqAddr[1:0]),
    .addrHigh     (addrHigh),
    .strobe       (strobe)
  );

  lsu_datapath #(.ADDR_EXP(ADDR_EXP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseAddr (reqAddr[ADDR_EXP-1:0]),
    .reqWData (reqWData),
    .rspValid (rspValid),
    .rspRData (rspRData),
    .rspFault (rspFault)
  );

  // R4: misaligned word faults on the next cycle
  p_word_misalign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd2 && reqAddr[1:0] != 2'b00) |=> rspFault);

  // R7: an in-range byte access never faults
  p_byte_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0 && !addrHigh) |=> !rspFault);

  // R9: no request, no response or fault
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspFault));
endmodule

// File: tb/endian_lsu_tb.sv
module endian_lsu_tb;
  localparam int AE = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBigEndian = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = 32'd0;
  logic [31:0] reqWData = 32'd0;
  logic        rspValid;
  logic [31:0] rspRData;
  logic        rspFault;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  endian_lsu #(.ADDR_EXP(AE)) u_dut (
    .clk(clk), .rstN(rstN), .cfgBigEndian(cfgBigEndian),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWData(reqWData),
    .rspValid(rspValid), .rspRData(rspRData), .rspFault(rspFault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic big);
    @(negedge clk);
    rstN = 1'b0;
    cfgBigEndian = big;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Issue one request, return the registered response
  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output logic flt);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    rd  = rspRData;
    flt = rspFault;
    check("R9 rspValid", {31'd0, rspValid}, 32'd1);
  endtask

  task automatic readExp(input string tag, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] exp);
    logic [31:0] rd; logic flt;
    access(1'b0, sz, a, 32'd0, rd, flt);
    check({tag, " data"}, rd, exp);
    check({tag, " fault"}, {31'd0, flt}, 32'd0);
  endtask

  task automatic writeOk(input string tag, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd);
    logic [31:0] rd; logic flt;
    access(1'b1, sz, a, wd, rd, flt);
    check({tag, " R9 write data zero"}, rd, 32'd0);
    check({tag, " fault"}, {31'd0, flt}, 32'd0);
  endtask

  task automatic expectFault(input string tag, input logic wr, input logic [1:0] sz,
                             input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic flt;
    access(wr, sz, a, wd, rd, flt);
    check({tag, " fault"}, {31'd0, flt}, 32'd1);
    check({tag, " R4 zero data"}, rd, 32'd0);
    @(negedge clk);
    check({tag, " R9 fault pulse"}, {30'd0, rspValid, rspFault}, 32'd0);
  endtask

  task automatic t_reset;
    doReset(1'b0);
    check("R9 reset valid", {31'd0, rspValid}, 32'd0);
    check("R9 reset fault", {31'd0, rspFault}, 32'd0);
  endtask

  task automatic t_littleWord;
    writeOk("R1 store", 2'd2, 32'h10, 32'hA1B2C3D4);
    readExp("R1 byte0", 2'd0, 32'h10, 32'h000000D4);
    readExp("R1 byte1", 2'd0, 32'h11, 32'h000000C3);
    readExp("R1 byte2", 2'd0, 32'h12, 32'h000000B2);
    readExp("R1 byte3", 2'd0, 32'h13, 32'h000000A1);
    readExp("R2 word",  2'd2, 32'h10, 32'hA1B2C3D4);
    readExp("R3 le half lo", 2'd1, 32'h10, 32'h0000C3D4);
    readExp("R3 le half hi", 2'd1, 32'h12, 32'h0000A1B2);
  endtask

  task automatic t_byteWrite;
    writeOk("R7 le byte", 2'd0, 32'h11, 32'hFFFFFF55);
    readExp("R7 le neighbours", 2'd2, 32'h10, 32'hA1B255D4);
  endtask

  task automatic t_misaligned;
    expectFault("R4 word rd", 1'b0, 2'd2, 32'h12, 32'd0);
    expectFault("R4 half rd", 1'b0, 2'd1, 32'h13, 32'd0);
    expectFault("R4 half wr", 1'b1, 2'd1, 32'h11, 32'h0000EEEE);
    expectFault("R4 word wr", 1'b1, 2'd2, 32'h12, 32'h77777777);
    readExp("R5 unchanged", 2'd2, 32'h10, 32'hA1B255D4);
  endtask

  task automatic t_range;
    expectFault("R8 high rd", 1'b0, 2'd2, 32'h1 << AE, 32'd0);
    expectFault("R8 high wr", 1'b1, 2'd0, (32'h1 << AE) + 32'h10, 32'h000000EE);
    expectFault("R8 top bit", 1'b1, 2'd2, 32'h80000010, 32'h12345678);
    expectFault("R8 size3",  1'b0, 2'd3, 32'h10, 32'd0);
    expectFault("R8 size3 wr", 1'b1, 2'd3, 32'h10, 32'hDEADBEEF);
    readExp("R8 no wrap write", 2'd2, 32'h10, 32'hA1B255D4);
  endtask

  task automatic t_big;
    doReset(1'b1);
    readExp("R3 be word", 2'd2, 32'h10, 32'hD455B2A1);
    readExp("R3 be half lo", 2'd1, 32'h10, 32'h0000D455);
    readExp("R3 be half hi", 2'd1, 32'h12, 32'h0000B2A1);
    readExp("R7 be byte", 2'd0, 32'h11, 32'h00000055);
    writeOk("R3 be store", 2'd2, 32'h20, 32'h11223344);
    readExp("R3 be byte first", 2'd0, 32'h20, 32'h00000011);
    readExp("R3 be byte last",  2'd0, 32'h23, 32'h00000044);
    writeOk("R3 be half store", 2'd1, 32'h24, 32'h0000ABCD);
    readExp("R3 be half byte", 2'd0, 32'h24, 32'h000000AB);
    writeOk("R7 be byte store", 2'd0, 32'h21, 32'h00000099);
    readExp("R7 be neighbours", 2'd2, 32'h20, 32'h11993344);
  endtask

  task automatic t_endianHold;
    @(negedge clk);
    cfgBigEndian = 1'b0;
    repeat (2) @(negedge clk);
    readExp("R6 hold after toggle", 2'd2, 32'h20, 32'h11993344);
    doReset(1'b0);
    readExp("R6 recapture le", 2'd2, 32'h20, 32'h44339911);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_littleWord();
    t_byteWrite();
    t_misaligned();
    t_range();
    t_big();
    t_endianHold();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule